// File: doc/BRIEF.md
# Unlock-Sequence Flash Erase Command Decoder

This block sits on the device side of a parallel flash bus and turns bus writes into erase commands. A chip erase or sector erase is accepted only after a fixed six-write sequence: two unlock writes, a setup write, two more unlock writes, and then the command write. Each bus write arrives as a single-cycle write-valid pulse carrying a word address and a data byte. A recognised command leaves the block as a one-cycle pulse. A sector erase pulse also carries the sector number, which is taken from the top bits of the address.

An erase scheduler outside this block reports its current phase. The phases are read-array, chip erase running, sector collection window, sector erase running, and erase suspended. The phase decides how a write is treated. During a chip erase every write is ignored. In the collection window, a write either adds a sector, requests a suspend, or cancels the sequence. While a sector erase runs, only suspend is honoured. While suspended, only resume is honoured. A hardware reset cancels any partial sequence and signals a return to read-array mode.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset, all command pulses are low and the unlock sequencer is at its first step.
- R2: In the read-array phase (phase code 0), the writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 make `chip_erase_o` high for exactly the one cycle after the sixth write.
- R3: In the read-array phase, the same five-write prefix followed by data 30 at any address makes `sect_erase_o` pulse. `sect_addr_o` then shows address bits [19:15] of that sixth write and holds that value until the next sector pulse.
- R4: During the prefix, a write whose address or data does not match the expected step returns the sequencer to its first step. A partial sequence is also discarded whenever the phase is not read-array.
- R5: In the chip-erase phase (code 1), no write produces any output pulse.
- R6: In the collection-window phase (code 2), data 30 pulses `sect_erase_o` with that write's sector, and data B0 pulses `erase_suspend_o`. Any other data pulses `read_array_o` and no command.
- R7: In the sector-erasing phase (code 3), data B0 at any address pulses `erase_suspend_o`. All other writes produce no pulse.
- R8: In the suspended phase (code 4), data 30 pulses `erase_resume_o`. All other writes produce no pulse.
- R9: `hw_reset_i` high on a clock edge pulses `read_array_o` in the next cycle, suppresses any command from a write at that edge, and discards a partial sequence.
- R10: At most one output pulse is high in any cycle, and each pulse lasts one cycle.
- R11: Unlock and chip-erase addresses are compared on address bits [11:0] only. Higher bits are ignored.
- R12: Phase codes 5 to 7 are treated like the chip-erase phase: no write produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_reset_i | input | 1 | Hardware reset request; aborts the sequence |
| wr_valid_i | input | 1 | Single-cycle bus write strobe |
| wr_addr_i | input | 20 | Word address of the write |
| wr_data_i | input | 8 | Data byte of the write |
| phase_i | input | 3 | Scheduler phase: 0 read, 1 chip erase, 2 window, 3 sector erasing, 4 suspended |
| chip_erase_o | output | 1 | One-cycle chip erase command |
| sect_erase_o | output | 1 | One-cycle sector erase command |
| sect_addr_o | output | 5 | Latched sector number of the last sector command |
| erase_suspend_o | output | 1 | One-cycle erase suspend command |
| erase_resume_o | output | 1 | One-cycle erase resume command |
| read_array_o | output | 1 | One-cycle return-to-read-array indication |

## Verification
Some properties are checked on every cycle. At most one output pulse is high at a time. The chip-erase phase never produces a pulse. The erasing phase ignores everything except suspend. A hardware reset is always followed by a read-array pulse. The sequencer is back at its first step after any abort. A sector pulse always carries the sector bits of the write that caused it.

Other behaviour needs ordered sequences of writes, so only the bench scenarios can show it:
- a full six-write sequence completes a command;
- a mismatch at any step loses the sequence;
- a hardware reset between the fifth and sixth writes prevents the command;
- upper address bits do not affect unlock matching.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    // Scheduler phase codes seen on phase_i
    typedef enum logic [2:0] {
        PH_READ      = 3'd0,
        PH_CHIP      = 3'd1,
        PH_WINDOW    = 3'd2,
        PH_ERASING   = 3'd3,
        PH_SUSPENDED = 3'd4
    } phase_e;

    // One-cycle command outputs, one bit each
    typedef struct packed {
        logic chip;
        logic sect;
        logic susp;
        logic resume;
        logic read_array;
    } cmd_t;

    localparam int          DATA_W      = 8;
    localparam int          KEY_ADDR_W  = 12;
    localparam int          SEQ_LEN     = 6;

    localparam logic [DATA_W-1:0] CODE_KEY1   = 8'hAA;
    localparam logic [DATA_W-1:0] CODE_KEY2   = 8'h55;
    localparam logic [DATA_W-1:0] CODE_SETUP  = 8'h80;
    localparam logic [DATA_W-1:0] CODE_CHIP   = 8'h10;
    localparam logic [DATA_W-1:0] CODE_SECT   = 8'h30;
    localparam logic [DATA_W-1:0] CODE_SUSP   = 8'hB0;
    localparam logic [DATA_W-1:0] CODE_RESUME = 8'h30;

    localparam logic [KEY_ADDR_W-1:0] KEY_ADDR_A = 12'h555;
    localparam logic [KEY_ADDR_W-1:0] KEY_ADDR_B = 12'h2AA;

    // Expected data byte at each prefix step
    function automatic logic [DATA_W-1:0] step_data(input int s);
        case (s)
            0, 3:    step_data = CODE_KEY1;
            1, 4:    step_data = CODE_KEY2;
            2:       step_data = CODE_SETUP;
            default: step_data = '0;
        endcase
    endfunction

    // Expected key address at each prefix step
    function automatic logic [KEY_ADDR_W-1:0] step_addr(input int s);
        case (s)
            1, 4:    step_addr = KEY_ADDR_B;
            default: step_addr = KEY_ADDR_A;
        endcase
    endfunction

endpackage

// File: rtl/fcd_unlock_seq.sv
module fcd_unlock_seq
    import flash_cmd_pkg::*;
#(
    parameter int KEY_W = KEY_ADDR_W,
    parameter int LEN   = SEQ_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort_i,
    input  logic              wr_valid_i,
    input  logic [KEY_W-1:0]  key_addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              chip_hit_o,
    output logic              sect_hit_o
);

    localparam int STEP_W = $clog2(LEN);
    localparam int LAST   = LEN - 1;

    logic [STEP_W-1:0] step_q, step_d;
    logic [LAST-1:0]   pre_match;
    logic              pre_hit;
    logic              at_last;

    // One comparator per prefix step
    for (genvar g = 0; g < LAST; g++) begin : g_step_cmp
        assign pre_match[g] = (key_addr_i == KEY_W'(step_addr(g))) &&
                              (data_i == step_data(g));
    end

    always_comb begin
        pre_hit = 1'b0;
        for (int s = 0; s < LAST; s++) begin
            if (step_q == STEP_W'(s)) pre_hit = pre_match[s];
        end
    end

    assign at_last    = (step_q == STEP_W'(LAST));
    assign chip_hit_o = wr_valid_i && at_last &&
                        (key_addr_i == KEY_W'(KEY_ADDR_A)) && (data_i == CODE_CHIP);
    assign sect_hit_o = wr_valid_i && at_last && (data_i == CODE_SECT);

    always_comb begin
        step_d = step_q;
        if (abort_i) begin
            step_d = '0;
        end else if (wr_valid_i) begin
            if (at_last)      step_d = '0;
            else if (pre_hit) step_d = step_q + STEP_W'(1);
            else              step_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= '0;
        else     step_q <= step_d;
    end

    // R4: any abort leaves the sequencer at its first step
    p_step_clear_r4: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> (step_q == '0));

    // R4: sequencer never runs past the command step
    p_step_bound_r4: assert property (@(posedge clk) disable iff (rst)
        step_q <= STEP_W'(LAST));

endmodule

// File: rtl/fcd_phase_filter.sv
module fcd_phase_filter
    import flash_cmd_pkg::*;
(
    input  logic [2:0]        phase_i,
    input  logic              hw_reset_i,
    input  logic              wr_valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              chip_hit_i,
    input  logic              sect_hit_i,
    output cmd_t              cmd_o
);

    always_comb begin
        cmd_o = '0;
        if (hw_reset_i) begin
            cmd_o.read_array = 1'b1;
        end else if (wr_valid_i) begin
            case (phase_i)
                PH_READ: begin
                    cmd_o.chip = chip_hit_i;
                    cmd_o.sect = sect_hit_i && !chip_hit_i;
                end
                PH_WINDOW: begin
                    if (data_i == CODE_SECT)      cmd_o.sect       = 1'b1;
                    else if (data_i == CODE_SUSP) cmd_o.susp       = 1'b1;
                    else                          cmd_o.read_array = 1'b1;
                end
                PH_ERASING:   cmd_o.susp   = (data_i == CODE_SUSP);
                PH_SUSPENDED: cmd_o.resume = (data_i == CODE_RESUME);
                default:      cmd_o        = '0;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int SECT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_reset_i,
    input  logic              wr_valid_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic [2:0]        phase_i,
    output logic              chip_erase_o,
    output logic              sect_erase_o,
    output logic [SECT_W-1:0] sect_addr_o,
    output logic              erase_suspend_o,
    output logic              erase_resume_o,
    output logic              read_array_o
);

    logic              seq_abort;
    logic              chip_hit, sect_hit;
    cmd_t              cmd_d, cmd_q;
    logic [SECT_W-1:0] sect_q;

    assign seq_abort = hw_reset_i || (phase_i != 3'(PH_READ));

    fcd_unlock_seq #(.KEY_W(KEY_ADDR_W), .LEN(SEQ_LEN)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .abort_i    (seq_abort),
        .wr_valid_i (wr_valid_i),
        .key_addr_i (wr_addr_i[KEY_ADDR_W-1:0]),
        .data_i     (wr_data_i),
        .chip_hit_o (chip_hit),
        .sect_hit_o (sect_hit)
    );

    fcd_phase_filter u_filter (
        .phase_i    (phase_i),
        .hw_reset_i (hw_reset_i),
        .wr_valid_i (wr_valid_i),
        .data_i     (wr_data_i),
        .chip_hit_i (chip_hit),
        .sect_hit_i (sect_hit),
        .cmd_o      (cmd_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            sect_q <= '0;
        end else begin
            cmd_q <= cmd_d;
            if (cmd_d.sect) sect_q <= wr_addr_i[ADDR_W-1 -: SECT_W];
        end
    end

    assign chip_erase_o    = cmd_q.chip;
    assign sect_erase_o    = cmd_q.sect;
    assign erase_suspend_o = cmd_q.susp;
    assign erase_resume_o  = cmd_q.resume;
    assign read_array_o    = cmd_q.read_array;
    assign sect_addr_o     = sect_q;

    // R10: at most one pulse per cycle
    p_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({chip_erase_o, sect_erase_o, erase_suspend_o, erase_resume_o, read_array_o}));

    // R10: chip erase is a single-cycle pulse
    p_chip_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        chip_erase_o |=> !chip_erase_o);

    // R5: chip-erase phase produces nothing
    p_chip_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (phase_i == 3'(PH_CHIP) && !hw_reset_i) |=>
        !(chip_erase_o || sect_erase_o || erase_suspend_o || erase_resume_o || read_array_o));

    // R7: erasing phase ignores all but suspend
    p_erasing_r7: assert property (@(posedge clk) disable iff (rst)
        (phase_i == 3'(PH_ERASING) && !hw_reset_i && wr_valid_i && wr_data_i != CODE_SUSP) |=>
        !(chip_erase_o || sect_erase_o || erase_suspend_o || erase_resume_o || read_array_o));

    // R9: hardware reset always reports read-array
    p_hwrst_r9: assert property (@(posedge clk) disable iff (rst)
        hw_reset_i |=> read_array_o);

    // R3: sector number comes from the causing write
    p_sect_addr_r3: assert property (@(posedge clk) disable iff (rst)
        (!hw_reset_i && wr_valid_i) |=>
        (!sect_erase_o || sect_addr_o == $past(wr_addr_i[ADDR_W-1 -: SECT_W])));

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hw_reset_i = 1'b0;
    logic        wr_valid_i = 1'b0;
    logic [19:0] wr_addr_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic [2:0]  phase_i = 3'd0;
    logic        chip_erase_o, sect_erase_o, erase_suspend_o, erase_resume_o, read_array_o;
    logic [4:0]  sect_addr_o;

    int n_tests = 0;
    int n_fail  = 0;
    int m_step  = 0;
    logic [4:0] m_sect = '0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_decoder u_dut (
        .clk(clk), .rst(rst), .hw_reset_i(hw_reset_i), .wr_valid_i(wr_valid_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .phase_i(phase_i),
        .chip_erase_o(chip_erase_o), .sect_erase_o(sect_erase_o), .sect_addr_o(sect_addr_o),
        .erase_suspend_o(erase_suspend_o), .erase_resume_o(erase_resume_o),
        .read_array_o(read_array_o)
    );

    function automatic logic [11:0] ref_addr(input int s);
        return (s == 1 || s == 4) ? 12'h2AA : 12'h555;
    endfunction

    function automatic logic [7:0] ref_data(input int s);
        case (s)
            0, 3:    return 8'hAA;
            1, 4:    return 8'h55;
            default: return 8'h80;
        endcase
    endfunction

    // {chip, sect, suspend, resume, read_array}
    function automatic logic [4:0] outs();
        return {chip_erase_o, sect_erase_o, erase_suspend_o, erase_resume_o, read_array_o};
    endfunction

    task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s pulses got %b expected %b", req, got, exp);
        end
    endtask

    task automatic check_sect(input string req);
        n_tests++;
        if (sect_addr_o !== m_sect) begin
            n_fail++;
            $display("FAIL %s sector got %0d expected %0d", req, sect_addr_o, m_sect);
        end
    endtask

    task automatic set_phase(input logic [2:0] p);
        @(negedge clk);
        phase_i = p;
        if (p != 3'd0) m_step = 0;
    endtask

    task automatic wr(input logic [19:0] a, input logic [7:0] d, input string req);
        logic [4:0] e;
        e = '0;
        case (phase_i)
            3'd0: begin
                if (m_step < 5) begin
                    if (a[11:0] == ref_addr(m_step) && d == ref_data(m_step)) m_step++;
                    else m_step = 0;
                end else begin
                    if (a[11:0] == 12'h555 && d == 8'h10) e[4] = 1'b1;
                    else if (d == 8'h30) e[3] = 1'b1;
                    m_step = 0;
                end
            end
            3'd2: begin
                if (d == 8'h30) e[3] = 1'b1;
                else if (d == 8'hB0) e[2] = 1'b1;
                else e[0] = 1'b1;
            end
            3'd3: e[2] = (d == 8'hB0);
            3'd4: e[1] = (d == 8'h30);
            default: e = '0;
        endcase
        if (e[3]) m_sect = a[19:15];
        @(negedge clk);
        wr_valid_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(posedge clk); #1;
        check(req, outs(), e);
        if (e[3]) check_sect(req);
        @(negedge clk);
        wr_valid_i = 1'b0;
    endtask

    task automatic prefix(input logic [19:0] hi, input string req);
        for (int s = 0; s < 5; s++) wr({hi[19:12], ref_addr(s)}, ref_data(s), req);
    endtask

    task automatic hw_pulse(input string req);
        @(negedge clk);
        hw_reset_i = 1'b1;
        @(posedge clk); #1;
        check(req, outs(), 5'b00001);
        @(negedge clk);
        hw_reset_i = 1'b0;
        m_step = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", outs(), 5'b0);
        @(negedge clk) rst = 1'b0;

        // R2 chip erase
        prefix(20'h00000, "R2 prefix");
        wr(20'h00555, 8'h10, "R2 chip erase");
        @(posedge clk); #1;
        check("R10 pulse one cycle", outs(), 5'b0);

        // R3 sector erase with R11 upper bits in unlock addresses
        prefix(20'hA5000, "R11 prefix");
        wr(20'hB8123, 8'h30, "R3 sector erase");
        check_sect("R3 sector held");

        // R4 mismatch at step 3 then remaining writes
        wr(20'h00555, 8'hAA, "R4");
        wr(20'h002AA, 8'h55, "R4");
        wr(20'h00555, 8'h81, "R4 bad setup");
        wr(20'h00555, 8'hAA, "R4");
        wr(20'h002AA, 8'h55, "R4");
        wr(20'h00555, 8'h10, "R4 no command");

        // R9 hw reset between fifth and sixth write
        prefix(20'h0, "R9 prefix");
        hw_pulse("R9 hw reset");
        wr(20'h00555, 8'h10, "R9 no command after reset");

        // R4 partial sequence dropped on phase change
        prefix(20'h0, "R4 prefix");
        set_phase(3'd3);
        set_phase(3'd0);
        wr(20'h00555, 8'h10, "R4 phase discard");

        // R5 chip phase
        set_phase(3'd1);
        wr(20'h12345, 8'hB0, "R5 suspend ignored");
        wr(20'h00555, 8'hAA, "R5 unlock ignored");

        // R6 window
        set_phase(3'd2);
        wr(20'h48000, 8'h30, "R6 add sector");
        wr(20'h00000, 8'hAA, "R6 other write");
        wr(20'hFFFFF, 8'hB0, "R6 suspend");

        // R7 erasing, R8 suspended, R12 reserved
        set_phase(3'd3);
        wr(20'h00555, 8'h30, "R7 ignored");
        wr(20'h7ABCD, 8'hB0, "R7 suspend");
        set_phase(3'd4);
        wr(20'h00000, 8'hB0, "R8 ignored");
        wr(20'h12000, 8'h30, "R8 resume");
        set_phase(3'd6);
        wr(20'h00000, 8'h30, "R12 reserved");
        wr(20'h00000, 8'hB0, "R12 reserved");

        // Random mixture
        for (int it = 0; it < 300; it++) begin
            int ph;
            ph = $urandom_range(0, 5);
            set_phase(3'(ph));
            if (ph == 0) begin
                int bad;
                logic [19:0] hi;
                bad = $urandom_range(0, 8);
                hi  = 20'($urandom);
                for (int s = 0; s < 5; s++) begin
                    if (s == bad) wr({hi[19:12], ref_addr(s)}, ref_data(s) ^ 8'h04, "R4 random");
                    else          wr({hi[19:12], ref_addr(s)}, ref_data(s), "R11 random");
                end
                if ($urandom_range(0, 1) == 0) wr({hi[19:12], 12'h555}, 8'h10, "R2 random");
                else                            wr(20'($urandom), 8'h30, "R3 random");
                if ($urandom_range(0, 9) == 0) hw_pulse("R9 random");
            end else begin
                logic [7:0] d;
                case ($urandom_range(0, 4))
                    0: d = 8'h30;
                    1: d = 8'hB0;
                    2: d = 8'h10;
                    3: d = 8'hAA;
                    default: d = 8'($urandom);
                endcase
                wr(20'($urandom), d, "R5-phase random R6 R7 R8 R12");
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule